// File: doc/BRIEF.md
# Serial Register-Write Receiver

This block is the slave end of a low-pin-count control port. A host writes one 16-bit control word per transaction, and the block splits that word into a 7-bit register address and a 9-bit register value for the control register file that sits beside it. The register file and any readback path are outside this block.

A static mode pin picks one of two physical framings, and both deliver the same word. The two-wire framing is I2C-like: a start condition, a device-address byte with a read/write bit, and two data bytes, each of them acknowledged. The three-wire framing is SPI-like: a select line, a clock and a data line. Every serial pin is sampled through synchronizers on the system clock. A completed word appears as a one-cycle write strobe, and the address and data outputs stay stable until the next commit.

Top module: `ctl_word_rx`

## Requirements
- R1: A committed word W gives wr_addr = W[15:9] and wr_data = W[8:0]. W arrives MSB first in both framings.
- R2: mode_3w = 1 selects the three-wire framing and mode_3w = 0 selects the two-wire framing. In three-wire mode a two-wire transaction gives no acknowledge and no strobe.
- R3: In two-wire mode, data is sampled on rising serial-clock edges while the clock is high. After a start condition (data falls while the clock is high), the first byte is the 7-bit device address followed by a R/W bit, where 0 means write. If the address equals DEV_ID and the bit is 0, sda_low is asserted for the ninth clock pulse.
- R4: In two-wire mode, the first data byte carries W[15:8] and the second carries W[7:0]. Both are acknowledged by asserting sda_low for their ninth clock. The word is committed after the acknowledge pulse of the second data byte.
- R5: In two-wire mode, a device address that does not match, or a R/W bit of 1, gets no acknowledge on any byte and produces no strobe.
- R6: In two-wire mode, a start or stop condition (data rises while the clock is high) in the middle of a word discards the partial word and produces no strobe.
- R7: In three-wire mode, bits are shifted in on rising serial-clock edges while ser_sel_n is low. The word is committed on the rising edge of ser_sel_n.
- R8: In three-wire mode, a select window that holds any number of clock edges other than 16 (for example 15 or 17) is discarded and produces no strobe.
- R9: wr_stb is high for exactly one clock per committed word. wr_addr and wr_data change only in a strobe cycle and otherwise keep their values.
- R10: While reset is held, and after it is released, wr_stb is 0, wr_addr and wr_data are 0, and sda_low is 0.
- R11: In two-wire mode, bytes after the second data byte are not acknowledged and do not cause another strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_3w | input | 1 | Framing select: 1 for three-wire, 0 for two-wire |
| ser_clk | input | 1 | Serial clock |
| ser_dat | input | 1 | Serial data, read from the bus line |
| ser_sel_n | input | 1 | Three-wire select, active low |
| sda_low | output | 1 | Pull the two-wire data line low (acknowledge) |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 7 | Register address of the last committed word |
| wr_data | output | 9 | Register value of the last committed word |

## Verification
The assertions assume that mode_3w stays constant for the whole of a transaction. They also assume that every serial level is held for several system clocks, so that each serial edge is seen exactly once after synchronization. The bench changes mode only while the bus is idle, and it holds every serial half period for ten system clocks. The bench also changes two-wire data only while the serial clock is low, except where it forms a deliberate start or stop condition.

// File: rtl/ctl_word_rx.sv
module ctl_word_rx #(
  parameter logic [6:0] DEV_ID = 7'h1A,
  parameter int SYNC_STAGES = 2,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_3w,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_sel_n,
  output logic              sda_low,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-ADDR_W-1:0] wr_data
);
  localparam int DATA_W = WORD_W - ADDR_W;
  localparam int CW = $clog2(WORD_W + 2);

  logic [SYNC_STAGES:0] clk_p, dat_p, sel_p;
  logic c_now, c_prev, d_now, d_prev, s_now, s_prev;
  logic c_rise, c_fall, sel_rise, sel_fall, start_c, stop_c;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      clk_p <= '1;
      dat_p <= '1;
      sel_p <= '1;
    end else begin
      clk_p <= {clk_p[SYNC_STAGES-1:0], ser_clk};
      dat_p <= {dat_p[SYNC_STAGES-1:0], ser_dat};
      sel_p <= {sel_p[SYNC_STAGES-1:0], ser_sel_n};
    end

  assign c_now  = clk_p[SYNC_STAGES-1];
  assign c_prev = clk_p[SYNC_STAGES];
  assign d_now  = dat_p[SYNC_STAGES-1];
  assign d_prev = dat_p[SYNC_STAGES];
  assign s_now  = sel_p[SYNC_STAGES-1];
  assign s_prev = sel_p[SYNC_STAGES];

  assign c_rise   = c_now & ~c_prev;
  assign c_fall   = ~c_now & c_prev;
  assign sel_rise = s_now & ~s_prev;
  assign sel_fall = ~s_now & s_prev;
  assign start_c  = c_now & c_prev & d_prev & ~d_now;
  assign stop_c   = c_now & c_prev & ~d_prev & d_now;

  logic [WORD_W-1:0] sr;
  logic [CW-1:0]     cnt;
  logic [1:0]        byte_idx;
  logic              hit, ack_q;

  assign sda_low = ack_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sr       <= '0;
      cnt      <= '0;
      byte_idx <= 2'd3;
      hit      <= 1'b0;
      ack_q    <= 1'b0;
      wr_stb   <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (mode_3w) begin
        ack_q    <= 1'b0;
        hit      <= 1'b0;
        byte_idx <= 2'd3;
        if (sel_fall) begin
          cnt <= '0;
        end else if (sel_rise) begin
          if (cnt == CW'(WORD_W)) begin
            wr_stb  <= 1'b1;
            wr_addr <= sr[WORD_W-1:DATA_W];
            wr_data <= sr[DATA_W-1:0];
          end
        end else if (!s_now && c_rise) begin
          sr <= {sr[WORD_W-2:0], d_now};
          if (cnt != CW'(WORD_W + 1)) cnt <= cnt + 1'b1;
        end
      end else begin
        if (start_c || stop_c) begin
          cnt      <= '0;
          hit      <= 1'b0;
          ack_q    <= 1'b0;
          byte_idx <= start_c ? 2'd0 : 2'd3;
        end else if (c_rise) begin
          if (cnt < CW'(8)) sr <= {sr[WORD_W-2:0], d_now};
          if (cnt != CW'(9)) cnt <= cnt + 1'b1;
        end else if (c_fall) begin
          if (cnt == CW'(8)) begin
            if (byte_idx == 2'd0)
              ack_q <= (sr[7:1] == DEV_ID) && !sr[0];
            else
              ack_q <= hit && (byte_idx != 2'd3);
          end else if (cnt == CW'(9)) begin
            ack_q <= 1'b0;
            cnt   <= '0;
            if (byte_idx == 2'd0) hit <= ack_q;
            if (byte_idx == 2'd2 && hit) begin
              wr_stb  <= 1'b1;
              wr_addr <= sr[WORD_W-1:DATA_W];
              wr_data <= sr[DATA_W-1:0];
            end
            if (byte_idx != 2'd3) byte_idx <= byte_idx + 1'b1;
          end
        end
      end
    end

  assert_stb_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |-> $stable({wr_addr, wr_data}));
  assert_commit_on_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mode_3w) |-> $past(sel_rise));
  assert_commit_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !mode_3w) |-> $past(c_fall));
  assert_ack_while_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_low) |-> !c_now);
  assert_no_ack_3w_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_3w && $past(mode_3w)) |-> !sda_low);
endmodule

// File: tb/ctl_word_rx_tb.sv
module ctl_word_rx_tb;
  localparam int HP = 10;
  localparam logic [6:0] DEV = 7'h1A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_3w = 1'b0;
  logic m_clk = 1'b1, m_dat = 1'b1, m_sel = 1'b1;
  logic sda_low, wr_stb;
  logic [6:0] wr_addr;
  logic [8:0] wr_data;
  logic line;

  int total = 0, bad = 0, stb_cnt = 0, run = 0, max_run = 0;
  bit done = 0;

  always #2 clk = ~clk;

  assign line = mode_3w ? m_dat : (m_dat & ~sda_low);

  ctl_word_rx #(.DEV_ID(DEV)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_3w(mode_3w),
    .ser_clk(m_clk), .ser_dat(line), .ser_sel_n(m_sel),
    .sda_low(sda_low), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  always @(negedge clk) begin
    if (wr_stb) begin
      stb_cnt++;
      run++;
      if (run > max_run) max_run = run;
    end else run = 0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tw_start();
    m_dat = 1'b1; hw(HP); m_clk = 1'b1; hw(HP);
    m_dat = 1'b0; hw(HP); m_clk = 1'b0; hw(HP);
  endtask

  task automatic tw_stop();
    m_dat = 1'b0; hw(HP); m_clk = 1'b1; hw(HP);
    m_dat = 1'b1; hw(HP);
  endtask

  task automatic tw_bit(input logic b);
    m_dat = b; hw(HP); m_clk = 1'b1; hw(HP); m_clk = 1'b0; hw(2);
  endtask

  task automatic tw_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) tw_bit(b[i]);
    m_dat = 1'b1; hw(HP); m_clk = 1'b1; hw(HP / 2);
    acked = ~line;
    hw(HP / 2); m_clk = 1'b0; hw(HP);
  endtask

  task automatic tw_write(input logic [6:0] dev, input logic rw, input logic [15:0] w,
                          output logic a0, output logic a1, output logic a2);
    tw_start();
    tw_byte({dev, rw}, a0);
    tw_byte(w[15:8], a1);
    tw_byte(w[7:0], a2);
    tw_stop();
    hw(HP);
  endtask

  task automatic sp_word(input logic [31:0] v, input int n);
    m_clk = 1'b0; m_sel = 1'b0; hw(HP);
    for (int i = n - 1; i >= 0; i--) begin
      m_dat = v[i]; hw(HP); m_clk = 1'b1; hw(HP); m_clk = 1'b0;
    end
    hw(HP); m_sel = 1'b1; hw(HP);
  endtask

  localparam int NV = 8;
  localparam logic [30:0] VEC [NV] = '{
    {1'b0, 7'h1A, 1'b0, 16'hA5C3, 5'd16, 1'b1},
    {1'b0, 7'h1A, 1'b0, 16'h01FF, 5'd16, 1'b1},
    {1'b0, 7'h1B, 1'b0, 16'h3C3C, 5'd16, 1'b0},
    {1'b0, 7'h1A, 1'b1, 16'h7E81, 5'd16, 1'b0},
    {1'b1, 7'h00, 1'b0, 16'hFE01, 5'd16, 1'b1},
    {1'b1, 7'h00, 1'b0, 16'h1234, 5'd15, 1'b0},
    {1'b1, 7'h00, 1'b0, 16'h5678, 5'd17, 1'b0},
    {1'b1, 7'h00, 1'b0, 16'h8000, 5'd16, 1'b1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic a0, a1, a2, a3;
    logic [15:0] prev;
    int s0;
    hw(5);
    chk("R10 stb in reset", wr_stb, 0);
    chk("R10 addr/data in reset", {wr_addr, wr_data}, 0);
    chk("R10 sda_low in reset", sda_low, 0);
    rst_n = 1'b1; hw(10);
    chk("R10 idle after reset", {sda_low, wr_stb, wr_addr, wr_data}, 0);
    prev = 16'h0000;

    for (int k = 0; k < NV; k++) begin
      logic md, rw, ex;
      logic [6:0] dv;
      logic [15:0] w;
      logic [4:0] nb;
      {md, dv, rw, w, nb, ex} = VEC[k];
      if (md != mode_3w) begin
        mode_3w = md; m_clk = ~md; m_dat = 1'b1; m_sel = 1'b1; hw(HP);
      end
      s0 = stb_cnt;
      if (md) sp_word({16'h0001, w}, int'(nb));
      else begin
        tw_write(dv, rw, w, a0, a1, a2);
        chk(ex ? "R3 address ack" : "R5 no address ack", a0, ex);
        chk(ex ? "R4 data acks" : "R5 no data acks", {a1, a2}, {ex, ex});
      end
      chk(md ? (ex ? "R7 3-wire commit count" : "R8 bad length discarded")
             : (ex ? "R4 2-wire commit count" : "R5 rejected no strobe"),
          stb_cnt - s0, ex);
      if (ex) prev = w;
      chk("R1 addr/data split", {wr_addr, wr_data}, {prev[15:9], prev[8:0]});
    end

    mode_3w = 1'b0; m_clk = 1'b1; m_dat = 1'b1; m_sel = 1'b1; hw(HP);

    s0 = stb_cnt;
    tw_start(); tw_byte({DEV, 1'b0}, a0); tw_byte(8'h55, a1);
    for (int i = 0; i < 4; i++) tw_bit(1'b0);
    m_dat = 1'b1; hw(HP); m_clk = 1'b1; hw(HP); m_dat = 1'b0; hw(HP); m_clk = 1'b0; hw(HP);
    tw_stop(); hw(HP);
    chk("R6 restart aborts word", stb_cnt - s0, 0);
    chk("R6 outputs held", {wr_addr, wr_data}, {prev[15:9], prev[8:0]});

    s0 = stb_cnt;
    tw_start(); tw_byte({DEV, 1'b0}, a0); tw_byte(8'h55, a1);
    for (int i = 0; i < 3; i++) tw_bit(1'b1);
    tw_stop(); hw(HP);
    chk("R6 stop aborts word", stb_cnt - s0, 0);

    s0 = stb_cnt;
    tw_start(); tw_byte({DEV, 1'b0}, a0); tw_byte(8'h9B, a1); tw_byte(8'h2D, a2);
    tw_byte(8'hF0, a3); tw_stop(); hw(HP);
    chk("R11 extra byte not acked", a3, 0);
    chk("R11 single strobe", stb_cnt - s0, 1);
    chk("R11 word kept", {wr_addr, wr_data}, {7'h4D, 9'h12D});
    prev = 16'h9B2D;

    chk("R9 strobe one cycle", max_run, 1);

    mode_3w = 1'b1; m_clk = 1'b0; m_dat = 1'b1; m_sel = 1'b1; hw(HP);
    s0 = stb_cnt;
    tw_write(DEV, 1'b0, 16'h4321, a0, a1, a2);
    chk("R2 no ack in 3-wire mode", {a0, a1, a2}, 0);
    chk("R2 no strobe from 2-wire frame", stb_cnt - s0, 0);
    chk("R2 outputs held", {wr_addr, wr_data}, {prev[15:9], prev[8:0]});

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule